// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the frame synchronization line of a serial audio port. It runs off a bit-clock enable pulse that the surrounding clocking logic provides, counts the bit positions of each frame and drives the sync line at a chosen level for a chosen number of bits. The sync line can lead slot 0 by one bit clock. It can also serve as a channel indicator: the active half of the frame is the left channel and the inactive half is the right channel.

Alongside the sync line the block gives three more outputs. One strobe marks the bit where sync becomes active. A second strobe marks the first bit of slot 0. A level output is high while the right-channel half of the frame is being sent. The configuration inputs are captured only while the block is disabled. While it runs, every change on them is ignored.

Top module: `afs_gen`

## Requirements
- R1: A frame is `frame_len_i + 1` bit clocks long, counted as bit positions 0 to `frame_len_i`. The position advances only on a clock where `bit_en_i` is high, and wraps from `frame_len_i` to 0. `slot0_o` is high during position 0 while enabled.
- R2: With `early_i` = 0 the sync line becomes active at position 0, and `frame_start_o` is high exactly when `slot0_o` is high. With `early_i` = 1 the sync line becomes active at the last position of the frame before, and `frame_start_o` is high at that position.
- R3: With `pol_i` = 1 the active level of `fs_o` is high. With `pol_i` = 0 the active level is low, so a frame begins on a falling edge.
- R4: With `chan_id_i` = 0 the sync line stays active for `act_len_i + 1` bits. If that is not less than the frame length, it is clamped to frame length minus 1, so sync always goes inactive at least one bit before the next frame starts.
- R5: With `chan_id_i` = 1, `act_len_i` is ignored and sync stays active for floor(L/2) bits, where L is the frame length. `right_o` is high at positions floor(L/2) and above, and low at the lower (left) positions. With `chan_id_i` = 0, `right_o` stays low.
- R6: All five configuration inputs are captured on every clock while `enable_i` is low. While `enable_i` is high they are held, so changes on them have no effect until the block has been disabled for one clock.
- R7: While `enable_i` is low, `fs_o` sits at the inactive level of the captured polarity, and `frame_start_o`, `slot0_o` and `right_o` are low. The position returns to 0, so the first bit after enabling is position 0.
- R8: After reset the captured configuration is a frame length field of 7 (8 bits), an active length field of 0, active-low polarity, no early offset and plain start-of-frame mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the generator; low holds it idle and opens configuration capture |
| bit_en_i | input | 1 | One-clock pulse per audio bit clock |
| frame_len_i | input | FL_W (8) | Frame length minus 1, in bit clocks |
| act_len_i | input | AL_W (7) | Sync active length minus 1, in bit clocks |
| pol_i | input | 1 | Sync active level: 1 high, 0 low |
| early_i | input | 1 | 1: sync leads slot 0 by one bit clock |
| chan_id_i | input | 1 | 1: sync also marks the left/right half |
| fs_o | output | 1 | Frame synchronization line |
| frame_start_o | output | 1 | High on the bit where sync becomes active |
| slot0_o | output | 1 | High on the first bit of slot 0 |
| right_o | output | 1 | High during the right-channel half (channel mode) |

## Verification
The bench targets the clamp, where an active length as long as or longer than the frame must leave one inactive bit. A design without the clamp would hold sync active for the whole frame and lose the frame edge. It uses odd frame lengths in channel mode, where a wrong halving would make the left and right halves uneven or misplace `right_o`. It also uses a one-bit frame, where the wrap and the early lead coincide. Configuration changes made while running must not alter the output. A design that captured them live would change polarity or frame length in the middle of a frame, and one that never recaptured would keep the old sync level after being disabled.

// File: rtl/afs_pkg.sv
package afs_pkg;

   typedef struct packed {
      logic pol;     // 1: sync active high
      logic early;   // 1: sync leads slot 0 by one bit
      logic chan;    // 1: sync also identifies the channel half
   } afs_mode_t;

   localparam afs_mode_t AFS_MODE_RST = '{pol: 1'b0, early: 1'b0, chan: 1'b0};

endpackage

// File: rtl/afs_cfg_shadow.sv
module afs_cfg_shadow
   import afs_pkg::*;
#(
   parameter int FL_W   = 8,
   parameter int AL_W   = 7,
   parameter int FL_RST = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable_i,
   input  logic [FL_W-1:0] frame_len_i,
   input  logic [AL_W-1:0] act_len_i,
   input  afs_mode_t       mode_i,
   output logic [FL_W-1:0] frame_len_q,
   output logic [AL_W-1:0] act_len_q,
   output afs_mode_t       mode_q
);

   localparam logic [FL_W-1:0] FL_RST_V = FL_W'(FL_RST);

   // Capture is open only while the generator is idle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_len_q <= FL_RST_V;
         act_len_q   <= '0;
         mode_q      <= AFS_MODE_RST;
      end else if (!enable_i) begin
         frame_len_q <= frame_len_i;
         act_len_q   <= act_len_i;
         mode_q      <= mode_i;
      end
   end

endmodule

// File: rtl/afs_bit_counter.sv
module afs_bit_counter #(
   parameter int FL_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable_i,
   input  logic            bit_en_i,
   input  logic [FL_W-1:0] last_i,
   output logic [FL_W-1:0] pos_o
);

   logic [FL_W-1:0] pos_q;
   logic            at_last;

   assign at_last = (pos_q == last_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (!enable_i) begin
         pos_q <= '0;
      end else if (bit_en_i) begin
         pos_q <= at_last ? '0 : pos_q + FL_W'(1);
      end
   end

   assign pos_o = pos_q;

endmodule

// File: rtl/afs_fs_decode.sv
module afs_fs_decode
   import afs_pkg::*;
#(
   parameter int FL_W    = 8,
   parameter int AL_W    = 7,
   parameter bit REG_OUT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable_i,
   input  logic [FL_W-1:0] pos_i,
   input  logic [FL_W-1:0] frame_len_i,
   input  logic [AL_W-1:0] act_len_i,
   input  afs_mode_t       mode_i,
   output logic            fs_o,
   output logic            frame_start_o,
   output logic            slot0_o,
   output logic            right_o
);

   localparam int LW = FL_W + 1;

   logic [LW-1:0] pos_w, len_w, half_w, al_w, act_w, sync_pos_w;
   logic          active;
   logic          fs_d, start_d, slot0_d, right_d;

   assign pos_w  = {1'b0, pos_i};
   assign len_w  = {1'b0, frame_len_i} + LW'(1);
   assign half_w = len_w >> 1;
   assign al_w   = LW'(act_len_i) + LW'(1);

   // Active length: half frame in channel mode, else clamped below the frame.
   always_comb begin
      if (mode_i.chan) begin
         act_w = half_w;
      end else if (al_w >= len_w) begin
         act_w = len_w - LW'(1);
      end else begin
         act_w = al_w;
      end
   end

   // Position on the sync time line: one ahead of the slot line when early.
   always_comb begin
      if (!mode_i.early) begin
         sync_pos_w = pos_w;
      end else if (pos_i == frame_len_i) begin
         sync_pos_w = '0;
      end else begin
         sync_pos_w = pos_w + LW'(1);
      end
   end

   assign active  = (sync_pos_w < act_w);
   assign fs_d    = enable_i ? (mode_i.pol ? active : !active) : !mode_i.pol;
   assign start_d = enable_i && (sync_pos_w == '0);
   assign slot0_d = enable_i && (pos_i == '0);
   assign right_d = enable_i && mode_i.chan && (pos_w >= half_w);

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fs_o          <= 1'b1;
               frame_start_o <= 1'b0;
               slot0_o       <= 1'b0;
               right_o       <= 1'b0;
            end else begin
               fs_o          <= fs_d;
               frame_start_o <= start_d;
               slot0_o       <= slot0_d;
               right_o       <= right_d;
            end
         end
      end else begin : g_comb_out
         assign fs_o          = fs_d;
         assign frame_start_o = start_d;
         assign slot0_o       = slot0_d;
         assign right_o       = right_d;
      end
   endgenerate

endmodule

// File: rtl/afs_gen.sv
module afs_gen
   import afs_pkg::*;
#(
   parameter int FL_W    = 8,
   parameter int AL_W    = 7,
   parameter int FL_RST  = 7,
   parameter bit REG_OUT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable_i,
   input  logic            bit_en_i,
   input  logic [FL_W-1:0] frame_len_i,
   input  logic [AL_W-1:0] act_len_i,
   input  logic            pol_i,
   input  logic            early_i,
   input  logic            chan_id_i,
   output logic            fs_o,
   output logic            frame_start_o,
   output logic            slot0_o,
   output logic            right_o
);

   initial begin
      assert (FL_W >= 2) else $error("afs_gen: FL_W must be at least 2");
      assert (AL_W >= 1 && AL_W <= FL_W) else $error("afs_gen: AL_W must be 1..FL_W");
      assert (FL_RST >= 0 && FL_RST < (1 << FL_W)) else $error("afs_gen: FL_RST out of range");
   end

   afs_mode_t       mode_in, mode_s;
   logic [FL_W-1:0] fl_s;
   logic [AL_W-1:0] al_s;
   logic [FL_W-1:0] pos;

   assign mode_in = '{pol: pol_i, early: early_i, chan: chan_id_i};

   afs_cfg_shadow #(.FL_W(FL_W), .AL_W(AL_W), .FL_RST(FL_RST)) i_shadow (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (enable_i),
      .frame_len_i (frame_len_i),
      .act_len_i   (act_len_i),
      .mode_i      (mode_in),
      .frame_len_q (fl_s),
      .act_len_q   (al_s),
      .mode_q      (mode_s)
   );

   afs_bit_counter #(.FL_W(FL_W)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable_i),
      .bit_en_i (bit_en_i),
      .last_i   (fl_s),
      .pos_o    (pos)
   );

   afs_fs_decode #(.FL_W(FL_W), .AL_W(AL_W), .REG_OUT(REG_OUT)) i_decode (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable_i      (enable_i),
      .pos_i         (pos),
      .frame_len_i   (fl_s),
      .act_len_i     (al_s),
      .mode_i        (mode_s),
      .fs_o          (fs_o),
      .frame_start_o (frame_start_o),
      .slot0_o       (slot0_o),
      .right_o       (right_o)
   );

endmodule

// File: rtl/afs_gen_chk.sv
module afs_gen_chk
   import afs_pkg::*;
#(
   parameter int FL_W    = 8,
   parameter bit REG_OUT = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            enable_i,
   input logic            bit_en_i,
   input logic            fs_o,
   input logic            frame_start_o,
   input logic            slot0_o,
   input logic            right_o,
   input afs_mode_t       mode_s,
   input logic [FL_W-1:0] fl_s,
   input logic [FL_W-1:0] pos
);

   generate
      if (!REG_OUT) begin : g_props
         assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !enable_i |-> (fs_o == !mode_s.pol) && !slot0_o && !frame_start_o && !right_o);

         assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
            enable_i && $past(enable_i) |-> $stable(mode_s) && $stable(fl_s));

         assert_pos_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
            pos <= fl_s);

         assert_pos_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            enable_i && $past(enable_i) && !$past(bit_en_i) |-> $stable(pos));

         assert_early_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
            enable_i && mode_s.early && frame_start_o && bit_en_i |=> !enable_i || slot0_o);

         assert_aligned_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
            enable_i && !mode_s.early |-> (frame_start_o == slot0_o));

         assert_start_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
            enable_i && slot0_o && !mode_s.early && (fl_s != '0) |-> (fs_o == mode_s.pol));

         assert_left_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
            slot0_o && mode_s.chan |-> !right_o);
      end
   endgenerate

endmodule

bind afs_gen afs_gen_chk #(.FL_W(FL_W), .REG_OUT(REG_OUT)) i_afs_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable_i      (enable_i),
   .bit_en_i      (bit_en_i),
   .fs_o          (fs_o),
   .frame_start_o (frame_start_o),
   .slot0_o       (slot0_o),
   .right_o       (right_o),
   .mode_s        (mode_s),
   .fl_s          (fl_s),
   .pos           (pos)
);

// File: tb/test_afs_gen.sv
module test_afs_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       be = 1'b0;
   logic [7:0] fl_i = 8'd0;
   logic [6:0] al_i = 7'd0;
   logic       pol_i = 1'b0, early_i = 1'b0, chan_i = 1'b0;
   logic       fs, fstart, slot0, right;

   int n_chk = 0;
   int n_bad = 0;
   int act_cnt = 0;

   // Expected-state model built from the requirements.
   logic [7:0] fl_m = 8'd7;
   logic [6:0] al_m = 7'd0;
   logic       pol_m = 1'b0, early_m = 1'b0, chan_m = 1'b0;
   logic [7:0] pos_m = 8'd0;

   always #10 clk = ~clk;

   afs_gen i_afs_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable_i      (en),
      .bit_en_i      (be),
      .frame_len_i   (fl_i),
      .act_len_i     (al_i),
      .pol_i         (pol_i),
      .early_i       (early_i),
      .chan_id_i     (chan_i),
      .fs_o          (fs),
      .frame_start_o (fstart),
      .slot0_o       (slot0),
      .right_o       (right)
   );

   typedef struct packed {
      logic [7:0] fl;
      logic [6:0] al;
      logic       pol;
      logic       early;
      logic       chan;
      logic [1:0] gap;
      logic [7:0] n_act;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'd7,  7'd0,  1'b1, 1'b0, 1'b0, 2'd0, 8'd1},   // R4 shortest pulse
      '{8'd7,  7'd3,  1'b0, 1'b1, 1'b0, 2'd0, 8'd4},   // R2 early, R3 low
      '{8'd9,  7'd20, 1'b1, 1'b0, 1'b0, 2'd1, 8'd9},   // R4 clamp (over)
      '{8'd15, 7'd2,  1'b1, 1'b1, 1'b1, 2'd0, 8'd8},   // R5 ignores act len
      '{8'd10, 7'd0,  1'b0, 1'b0, 1'b1, 2'd2, 8'd5},   // R5 odd frame
      '{8'd31, 7'd15, 1'b1, 1'b0, 1'b0, 2'd0, 8'd16},  // R4 mid length
      '{8'd0,  7'd0,  1'b1, 1'b1, 1'b0, 2'd0, 8'd0},   // R1 one-bit frame
      '{8'd4,  7'd4,  1'b1, 1'b1, 1'b0, 2'd1, 8'd4}    // R4 clamp (equal)
   };

   task automatic chk(input string tag, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic chk_int(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // Called at a falling edge: drive bit_en, check outputs, advance the model.
   task automatic tick(input logic b);
      int len, half, act, spos;
      logic a, e_fs, e_st, e_s0, e_rt;
      be = b;
      #1;
      len  = int'(fl_m) + 1;
      half = len / 2;
      if (chan_m)                   act = half;
      else if (int'(al_m) + 1 >= len) act = len - 1;
      else                          act = int'(al_m) + 1;
      if (early_m) spos = (pos_m == fl_m) ? 0 : int'(pos_m) + 1;
      else         spos = int'(pos_m);
      a    = en && (spos < act);
      e_fs = en ? (pol_m ? a : !a) : !pol_m;
      e_st = en && (spos == 0);
      e_s0 = en && (pos_m == 8'd0);
      e_rt = en && chan_m && (int'(pos_m) >= half);
      chk("R1 slot0_o", slot0, e_s0);
      chk("R2 frame_start_o", fstart, e_st);
      chk("R3/R4/R7 fs_o", fs, e_fs);
      chk("R5 right_o", right, e_rt);
      if (b && en && (fs == pol_m)) act_cnt++;
      @(posedge clk);
      if (rst_n) begin
         if (!en) begin
            pos_m = 8'd0;
            fl_m = fl_i; al_m = al_i; pol_m = pol_i; early_m = early_i; chan_m = chan_i;
         end else if (b) begin
            pos_m = (pos_m == fl_m) ? 8'd0 : pos_m + 8'd1;
         end
      end
      @(negedge clk);
   endtask

   task automatic set_cfg(input logic [7:0] f, input logic [6:0] l,
                          input logic p, input logic e, input logic c);
      fl_i = f; al_i = l; pol_i = p; early_i = e; chan_i = c;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      // Reset state (R8, R7): idle, active-low inactive level is high.
      set_cfg(8'd3, 7'd2, 1'b1, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      chk("R8 fs_o idle after reset", fs, 1'b1);
      chk("R7 slot0_o idle", slot0, 1'b0);
      chk("R7 frame_start_o idle", fstart, 1'b0);
      chk("R7 right_o idle", right, 1'b0);

      // Enable together with reset release: reset configuration stays (R8).
      rst_n = 1'b1;
      en    = 1'b1;
      act_cnt = 0;
      for (int i = 0; i < 16; i++) tick(1'b1);
      chk_int("R8 reset frame: active bits in 2 frames", act_cnt, 2);

      // Vector table walk.
      for (int v = 0; v < NV; v++) begin
         en = 1'b0;
         set_cfg(VECS[v].fl, VECS[v].al, VECS[v].pol, VECS[v].early, VECS[v].chan);
         tick(1'b0);
         tick(1'b0);
         en = 1'b1;
         act_cnt = 0;
         for (int bt = 0; bt < 2 * (int'(VECS[v].fl) + 1); bt++) begin
            for (int g = 0; g < int'(VECS[v].gap); g++) tick(1'b0);
            tick(1'b1);
         end
         chk_int("R4/R5 active bits in 2 frames", act_cnt, 2 * int'(VECS[v].n_act));
      end

      // R6: changes while running are ignored, taken after disabling.
      en = 1'b0;
      set_cfg(8'd7, 7'd1, 1'b1, 1'b0, 1'b0);
      tick(1'b0);
      tick(1'b0);
      en = 1'b1;
      for (int i = 0; i < 3; i++) tick(1'b1);
      set_cfg(8'd3, 7'd0, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 13; i++) tick(1'b1);
      en = 1'b0;
      #1;
      chk("R6 old polarity held until capture", fs, 1'b0);
      tick(1'b0);
      #1;
      chk("R6 new polarity after capture", fs, 1'b1);
      tick(1'b0);
      en = 1'b1;
      act_cnt = 0;
      for (int i = 0; i < 8; i++) tick(1'b1);
      chk_int("R6/R5 new frame active bits", act_cnt, 4);

      // R7: disable mid-frame, position restarts at 0.
      for (int i = 0; i < 2; i++) tick(1'b1);
      en = 1'b0;
      tick(1'b1);
      en = 1'b1;
      #1;
      chk("R7 restart at position 0", slot0, 1'b1);
      for (int i = 0; i < 4; i++) tick(1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule